// File: doc/BRIEF.md
# Single-Line Serial Flash Command Sequencer

The block runs one serial flash command at a time, built by software in a small register set. Software writes an optional command address, up to eight bytes of outgoing data and a control word. The control word holds an opcode, address enable and byte count, dummy clock count, read or write enable and data byte count, and an execute bit. Setting execute starts the command. Software then polls a busy flag and, after a read, collects up to eight returned bytes from two read-only 32-bit words.

On the serial side the block drives chip select, a serial clock that idles low, and one data-out line, and it samples one data-in line. Each command goes through the phases in this order: opcode, address, dummy clocks, data. Any phase that is not enabled is skipped. Outgoing bits change while the clock is low. Incoming bits are sampled at the end of the high half of each clock.

The sequencer state machine has these states. `ST_IDLE` waits for a start. `ST_OPCODE`, `ST_ADDR`, `ST_DUMMY`, `ST_WDATA` and `ST_RDATA` are the active phases. `ST_DONE` is a one-cycle tail with chip select released. The transitions are:
- start: `ST_IDLE` to `ST_OPCODE`.
- phase end: each active phase moves to the next enabled phase, or to `ST_DONE` when no enabled phase remains.
- release: `ST_DONE` to `ST_IDLE`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset all six registers read zero, chip select is high (inactive), the serial clock is low and data-out is low.
- R2: The register select values are 0 control, 1 command address, 2 write data low, 3 write data high, 4 read data low, 5 read data high.
  - Control bit positions: execute 0, busy 1, dummy 11:7, write count minus one 14:12, write enable 15, address count minus one 17:16, address enable 19, read count minus one 22:20, read enable 23, opcode 31:24.
  - Control reads back the stored fields, with bit 0 always 0 and bit 1 showing busy. Bits 2 to 6 and bit 18 read 0.
  - Registers 1 to 3 read back as written.
- R3: Writing control with bit 0 set starts a command. Busy reads 1 from the next register read until the command completes, and chip select stays low for every active phase.
- R4: The phases run in the order opcode, address, dummy, data. The number of serial clock pulses is 8 + 8·A + D + 8·N, where A and N are the enabled address and data byte counts and D is the dummy count.
- R5: The opcode is sent MSB first. When address enable is set, the lowest A bytes of the address register follow, most significant of those first. When address enable is clear, no address is sent.
- R6: A non-zero dummy count gives that many serial clock pulses with data-out low. A count of zero skips the phase.
- R7: Write data is sent starting at byte 0 of the low word and going upward, each byte MSB first. Only the requested number of bytes is sent.
- R8: Read bytes are stored starting at byte 0 of the low word, the first bit received being each byte's MSB. Bytes beyond the requested count read zero. Commands without a read leave the read data unchanged.
- R9: A control write with execute, read enable and write enable all set stores its fields but starts nothing: busy stays 0 and chip select stays high.
- R10: A control write while busy is ignored. The stored fields and the running command are unaffected, and no second command starts.
- R11: Writes to select values 4 and 5 do not change the read data.
- R12: Each serial clock period is 2·HALF_DIV system clocks, and data-out does not change while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the current select |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The embedded properties check these on every cycle:
- a control write while the sequencer is locked leaves the stored control fields unchanged;
- chip select falls on the cycle after a start is accepted;
- the serial clock is low whenever chip select is high;
- data-out holds steady through each high half of the serial clock;
- read data moves only while a command is running.

Only the bench scenarios can show the things that depend on what a flash model sees across a whole command:
- the exact bit stream on data-out for each mix of phases;
- the pulse count;
- the byte placement of returned data;
- the refusal of a combined read and write request.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic [7:0] opcode;
        logic       rd_en;
        logic [2:0] rd_cnt;
        logic       addr_en;
        logic [1:0] addr_cnt;
        logic       wr_en;
        logic [2:0] wr_cnt;
        logic [4:0] dummy;
    } cmd_t;

    // control word bit positions (software visible)
    localparam int POS_EXEC    = 0;
    localparam int POS_WR_EN   = 15;
    localparam int POS_RD_EN   = 23;
    localparam logic [31:0] CTRL_KEEP = 32'hFFFB_FF80;

    // register select values
    localparam int SEL_CTRL = 0;
    localparam int SEL_ADDR = 1;
    localparam int SEL_WLO  = 2;
    localparam int SEL_WHI  = 3;
    localparam int SEL_RLO  = 4;
    localparam int SEL_RHI  = 5;

    function automatic cmd_t decode_ctrl(input logic [31:0] w);
        cmd_t c;
        c.opcode   = w[31:24];
        c.rd_en    = w[23];
        c.rd_cnt   = w[22:20];
        c.addr_en  = w[19];
        c.addr_cnt = w[17:16];
        c.wr_en    = w[15];
        c.wr_cnt   = w[14:12];
        c.dummy    = w[11:7];
        return c;
    endfunction

endpackage

// File: rtl/fcs_regs.sv
module fcs_regs
    import fcs_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              seq_busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output cmd_t              cmd,
    output logic [31:0]       cmd_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic [31:0] ctrl_q;
    logic [31:0] addr_q;
    logic [31:0] wlo_q;
    logic [31:0] whi_q;
    logic        start_q;
    logic        locked;
    logic        ctrl_hit;
    logic        launch;

    assign locked   = seq_busy || start_q;
    assign ctrl_hit = cfg_wr && (cfg_sel == SEL_W'(SEL_CTRL));
    assign launch   = ctrl_hit && !locked && cfg_wdata[POS_EXEC]
                      && !(cfg_wdata[POS_RD_EN] && cfg_wdata[POS_WR_EN]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            addr_q  <= '0;
            wlo_q   <= '0;
            whi_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= launch;
            if (ctrl_hit && !locked)
                ctrl_q <= cfg_wdata & CTRL_KEEP;
            if (cfg_wr && cfg_sel == SEL_W'(SEL_ADDR))
                addr_q <= cfg_wdata;
            if (cfg_wr && cfg_sel == SEL_W'(SEL_WLO))
                wlo_q <= cfg_wdata;
            if (cfg_wr && cfg_sel == SEL_W'(SEL_WHI))
                whi_q <= cfg_wdata;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_W'(SEL_CTRL): cfg_rdata = {ctrl_q[31:2], locked, 1'b0};
            SEL_W'(SEL_ADDR): cfg_rdata = addr_q;
            SEL_W'(SEL_WLO):  cfg_rdata = wlo_q;
            SEL_W'(SEL_WHI):  cfg_rdata = whi_q;
            SEL_W'(SEL_RLO):  cfg_rdata = rd_data[31:0];
            SEL_W'(SEL_RHI):  cfg_rdata = rd_data[63:32];
            default:          cfg_rdata = '0;
        endcase
    end

    assign start    = start_q;
    assign cmd      = decode_ctrl(ctrl_q);
    assign cmd_addr = addr_q;
    assign wr_data  = {whi_q, wlo_q};

    // R10
    locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && locked) |=> $stable(ctrl_q));

endmodule

// File: rtl/fcs_bit_timer.sv
module fcs_bit_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck_hi,
    output logic bit_end
);

    localparam int TICKS = 2 * HALF_DIV;
    localparam int TW    = (TICKS > 2) ? $clog2(TICKS) : 1;

    logic [TW-1:0] tmr;

    assign bit_end = run && (tmr == TW'(TICKS - 1));
    assign sck_hi  = run && (tmr >= TW'(HALF_DIV));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tmr <= '0;
        else if (!run || bit_end)
            tmr <= '0;
        else
            tmr <= tmr + TW'(1);
    end

endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
    import fcs_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int MAX_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  cmd_t                   cmd,
    input  logic [31:0]            cmd_addr,
    input  logic [8*MAX_BYTES-1:0] wr_data,
    input  logic                   spi_miso,
    output logic                   busy,
    output logic [8*MAX_BYTES-1:0] rd_data,
    output logic                   spi_cs_n,
    output logic                   spi_sck,
    output logic                   spi_mosi
);

    localparam int SR_W = 8 * MAX_BYTES;
    localparam int IW   = $clog2(SR_W) + 1;
    localparam int BW   = $clog2(MAX_BYTES);

    seq_state_t      state;
    seq_state_t      follow;
    logic [SR_W-1:0] tx_sr;
    logic [6:0]      rx_byte;
    logic [IW-1:0]   bit_idx;
    logic [IW-1:0]   phase_len;
    logic            active;
    logic            sck_hi;
    logic            bit_end;
    logic            phase_last;

    fcs_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active),
        .sck_hi  (sck_hi),
        .bit_end (bit_end)
    );

    function automatic seq_state_t next_phase(input seq_state_t s, input cmd_t c);
        seq_state_t r;
        r = ST_DONE;
        if (s != ST_WDATA && s != ST_RDATA) begin
            if (c.rd_en) r = ST_RDATA;
            if (c.wr_en) r = ST_WDATA;
            if (s != ST_DUMMY && c.dummy != 5'd0) r = ST_DUMMY;
            if (s == ST_OPCODE && c.addr_en) r = ST_ADDR;
        end
        return r;
    endfunction

    function automatic logic [SR_W-1:0] tx_image(input seq_state_t s, input cmd_t c,
                                                  input logic [31:0] a,
                                                  input logic [SR_W-1:0] wd);
        logic [SR_W-1:0] img;
        img = '0;
        case (s)
            ST_OPCODE: img[SR_W-1 -: 8] = c.opcode;
            ST_ADDR:   img[SR_W-1 -: 32] = a << ({3'd0, ~c.addr_cnt} * 5'd8);
            ST_WDATA:  for (int k = 0; k < MAX_BYTES; k++)
                           img[SR_W-1-8*k -: 8] = wd[8*k +: 8];
            default:   img = '0;
        endcase
        return img;
    endfunction

    always_comb begin
        follow = next_phase(state, cmd);
        unique case (state)
            ST_OPCODE: phase_len = IW'(8);
            ST_ADDR:   phase_len = IW'({cmd.addr_cnt, 3'b000}) + IW'(8);
            ST_DUMMY:  phase_len = IW'(cmd.dummy);
            ST_WDATA:  phase_len = IW'({cmd.wr_cnt, 3'b000}) + IW'(8);
            ST_RDATA:  phase_len = IW'({cmd.rd_cnt, 3'b000}) + IW'(8);
            default:   phase_len = IW'(8);
        endcase
        phase_last = (bit_idx == phase_len - IW'(1));
    end

    // state register and shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            tx_sr   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_OPCODE;
                    bit_idx <= '0;
                    tx_sr   <= tx_image(ST_OPCODE, cmd, cmd_addr, wr_data);
                end
                ST_DONE: state <= ST_IDLE;
                default: if (bit_end) begin
                    if (phase_last) begin
                        state   <= follow;
                        bit_idx <= '0;
                        tx_sr   <= tx_image(follow, cmd, cmd_addr, wr_data);
                    end else begin
                        bit_idx <= bit_idx + IW'(1);
                        tx_sr   <= tx_sr << 1;
                    end
                end
            endcase
        end
    end

    // receive path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte <= '0;
            rd_data <= '0;
        end else if (state == ST_IDLE && start && cmd.rd_en) begin
            rd_data <= '0;
        end else if (state == ST_RDATA && bit_end) begin
            rx_byte <= {rx_byte[5:0], spi_miso};
            if (bit_idx[2:0] == 3'b111)
                rd_data[{bit_idx[BW+2:3], 3'b000} +: 8] <= {rx_byte, spi_miso};
        end
    end

    // outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        active   = (state != ST_IDLE) && (state != ST_DONE);
        spi_cs_n = !active;
        spi_sck  = active && sck_hi;
        spi_mosi = active && tx_sr[SR_W-1];
    end

    // R3
    cs_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> !spi_cs_n);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(rd_data));

    // R12
    mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);

    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = 8 * MAX_BYTES;

    logic              start;
    logic              busy;
    cmd_t              cmd;
    logic [31:0]       cmd_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    fcs_regs #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .seq_busy  (busy),
        .rd_data   (rd_data),
        .start     (start),
        .cmd       (cmd),
        .cmd_addr  (cmd_addr),
        .wr_data   (wr_data)
    );

    fcs_engine #(.HALF_DIV(HALF_DIV), .MAX_BYTES(MAX_BYTES)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd),
        .cmd_addr (cmd_addr),
        .wr_data  (wr_data),
        .spi_miso (spi_miso),
        .busy     (busy),
        .rd_data  (rd_data),
        .spi_cs_n (spi_cs_n),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi)
    );

    // R1
    sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

    localparam int HALF = 2;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] addr;
        logic [31:0] wlo;
        logic [31:0] whi;
        logic [63:0] resp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0600_0001, 32'h0, 32'h0, 32'h0, 64'h0},
        '{32'h020A_A001, 32'h0012_3456, 32'hDDCC_BBAA, 32'h4433_2211, 64'h0},
        '{32'h0BFB_0401, 32'h1020_3040, 32'h0, 32'h0, 64'h8877_6655_4433_2211},
        '{32'h9FA0_0001, 32'h0, 32'h0, 32'h0, 64'hFFFF_FFFF_FFC2_B1A0},
        '{32'hA508_F281, 32'hABCD_EF5A, 32'h0123_4567, 32'h89AB_CDEF, 64'h0},
        '{32'hD809_0F81, 32'h00AA_BBCC, 32'h0, 32'h0, 64'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    flash_cmd_seq #(.HALF_DIV(HALF), .SEL_W(3)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .spi_cs_n  (spi_cs_n),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    // flash model
    int          rises = 0;
    int          cs_falls = 0;
    int          base = 0;
    int          rd_off = 0;
    logic [63:0] resp = 64'd0;
    bit          mlog [0:4095];
    realtime     last_rise = 0.0;
    realtime     prev_rise = 0.0;

    always @(posedge spi_sck) begin
        if (rises < 4096) mlog[rises] = spi_mosi;
        prev_rise = last_rise;
        last_rise = $realtime;
        rises = rises + 1;
    end

    always @(negedge spi_sck or negedge spi_cs_n) begin
        int j;
        j = rises - base - rd_off;
        if (j >= 0 && j < 64) spi_miso = resp[8*(j/8) + 7 - (j%8)];
        else spi_miso = 1'b0;
    end

    always @(negedge spi_cs_n) cs_falls = cs_falls + 1;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 100000) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog R3 actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic write_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_sel = 3'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic read_reg(input int a, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = 3'(a);
        #1 d = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        for (int i = 0; i < 3000; i++) begin
            read_reg(0, r);
            if (!r[1]) break;
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] r;
        logic [63:0] exp_rd;
        bit          es [0:255];
        int          n, ab, dm, nb, bad, first_bad;
        logic [7:0]  by;
        ab = v.ctrl[19] ? 8 * (int'(v.ctrl[17:16]) + 1) : 0;
        dm = int'(v.ctrl[11:7]);
        nb = v.ctrl[15] ? int'(v.ctrl[14:12]) + 1 : (v.ctrl[23] ? int'(v.ctrl[22:20]) + 1 : 0);
        base = rises;
        rd_off = 8 + ab + dm;
        resp = v.resp;
        write_reg(1, v.addr);
        write_reg(2, v.wlo);
        write_reg(3, v.whi);
        read_reg(1, r);
        check(r == v.addr, "R2 address readback", 64'(r), 64'(v.addr));
        write_reg(0, v.ctrl);
        read_reg(0, r);
        check(r[1] == 1'b1, "R3 busy after execute", 64'(r[1]), 64'd1);
        wait_idle();
        check(rises - base == 8 + ab + dm + 8 * nb, "R4 pulse count",
              64'(rises - base), 64'(8 + ab + dm + 8 * nb));
        // expected data-out stream
        n = 0;
        for (int i = 7; i >= 0; i--) begin es[n] = v.ctrl[24 + i]; n++; end
        for (int b = ab / 8 - 1; b >= 0; b--)
            for (int i = 7; i >= 0; i--) begin es[n] = v.addr[8*b + i]; n++; end
        for (int i = 0; i < dm; i++) begin es[n] = 1'b0; n++; end
        for (int b = 0; b < nb; b++) begin
            by = {v.whi, v.wlo}[8*b +: 8];
            for (int i = 7; i >= 0; i--) begin
                es[n] = v.ctrl[15] ? by[i] : 1'b0;
                n++;
            end
        end
        bad = 0;
        first_bad = -1;
        for (int i = 0; i < n; i++)
            if (mlog[base + i] != es[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        check(bad == 0, "R5 R6 R7 data-out stream (actual=first bad bit)",
              64'(first_bad), 64'hFFFF_FFFF_FFFF_FFFF);
        read_reg(0, r);
        check(r == (v.ctrl & 32'hFFFB_FF80), "R2 control readback",
              64'(r), 64'(v.ctrl & 32'hFFFB_FF80));
        if (v.ctrl[23]) begin
            exp_rd = 64'd0;
            for (int b = 0; b < nb; b++) exp_rd[8*b +: 8] = v.resp[8*b +: 8];
            read_reg(4, r);
            check(r == exp_rd[31:0], "R8 read data low", 64'(r), 64'(exp_rd[31:0]));
            read_reg(5, r);
            check(r == exp_rd[63:32], "R8 read data high", 64'(r), 64'(exp_rd[63:32]));
        end
    endtask

    initial begin
        logic [31:0] r;
        int          b0, c0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_mosi == 1'b0,
              "R1 serial pins in reset", 64'({spi_cs_n, spi_sck, spi_mosi}), 64'b100);
        rst_n = 1'b1;
        for (int a = 0; a < 6; a++) begin
            read_reg(a, r);
            check(r == 32'd0, "R1 register after reset", 64'(r), 64'd0);
        end
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 idle pins",
              64'({spi_cs_n, spi_sck}), 64'b10);

        // table of command vectors
        for (int v = 0; v < 6; v++) begin
            run_vec(VECS[v]);
            if (v == 2)
                check(last_rise - prev_rise == real'(2 * HALF * 8), "R12 serial clock period",
                      64'(int'(last_rise - prev_rise)), 64'(2 * HALF * 8));
        end

        // R11 read data is read-only; R8 non-read commands kept it
        write_reg(4, 32'hDEAD_BEEF);
        write_reg(5, 32'hCAFE_F00D);
        read_reg(4, r);
        check(r == 32'h00C2_B1A0, "R11 read data low unchanged", 64'(r), 64'h00C2_B1A0);
        read_reg(5, r);
        check(r == 32'h0, "R11 read data high unchanged", 64'(r), 64'h0);

        // R9 read and write together refused
        b0 = rises;
        c0 = cs_falls;
        write_reg(0, 32'h0380_8001);
        read_reg(0, r);
        check(r == 32'h0380_8000, "R9 fields stored, not busy", 64'(r), 64'h0380_8000);
        repeat (40) @(negedge clk);
        check(rises == b0 && cs_falls == c0, "R9 no serial activity",
              64'(rises - b0 + cs_falls - c0), 64'd0);

        // R10 control write while busy
        write_reg(1, 32'h0000_1234);
        base = rises;
        rd_off = 1000;
        write_reg(0, 32'hD809_0F81);
        write_reg(0, 32'h1100_0001);
        read_reg(0, r);
        check(r == 32'hD809_0F82, "R10 control kept while busy", 64'(r), 64'hD809_0F82);
        wait_idle();
        check(rises - base == 55, "R10 single command pulses", 64'(rises - base), 64'd55);
        read_reg(0, r);
        check(r == 32'hD809_0F80, "R10 control after completion", 64'(r), 64'hD809_0F80);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R3 chip select released",
              64'({spi_cs_n, spi_sck}), 64'b10);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule